// File: doc/BRIEF.md
# Software Interrupt Dispatch Unit

This block turns a single 32-bit command word, written by a processor over a bus, into software interrupt requests for up to eight CPU interfaces. The word names an interrupt number, a requested group, an explicit target mask and a filter mode. The requesting processor's ID comes with the write. The filter mode selects one of three target sets: the listed interfaces, every interface except the requester's own, or the requester alone.

Every candidate target is then checked against that interface's group setting for the named interrupt. The check depends on whether the write was secure. Each target that passes gets a pending bit set in a CPU-by-interrupt pending array. A CPU clears its own bit with an acknowledge strobe that carries the interrupt number. A global enable input and a routing-mode input can each suppress command writes completely. The command register is write-only, and its read port always returns zero.

Top module: `swi_dispatch`

## Requirements
- R1: Command word fields: interrupt number in bits [3:0], requested group in bit 15 (0 = group 0, 1 = group 1), target mask in bits [23:16] (mask bit n selects CPU n), filter mode in bits [25:24]. All other bits have no effect.
- R2: Filter mode 2'b00 targets exactly the CPUs whose mask bit is set, so a zero mask sets no pending bit.
- R3: Filter mode 2'b01 targets every CPU except the requester given on `wr_cpu_i`.
- R4: Filter mode 2'b10 targets only the requester's own CPU.
- R5: Filter mode 2'b11 sets no pending bit.
- R6: On a secure write, a target receives the interrupt only when its group setting for that interrupt (`grp_cfg_i` bit cpu*16+id, 1 = group 1) equals the requested group bit.
- R7: On a non-secure write, the requested group bit is ignored. A target receives the interrupt when its setting is group 1, or when it is group 0 and `ns_g0_ok_i[id]` is 1.
- R8: While `route_mode_i` is 1, writes change no pending bit.
- R9: While `dist_en_i` is 0, writes change no pending bit.
- R10: An accepted write is visible on `pend_o` (bit cpu*16+id) in the cycle after the write strobe. Repeated writes leave a single pending bit, which one acknowledge removes.
- R11: `ack_vld_i[c]` with number `ack_id_i[c*4 +: 4]` clears that CPU's bit in the next cycle and touches no other bit. A set and a clear of the same bit in the same cycle leave it set.
- R12: `rd_data_o` is always zero.
- R13: After reset every pending bit is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dist_en_i | input | 1 | Global dispatch enable |
| route_mode_i | input | 1 | Alternate routing mode; suppresses command writes |
| wr_en_i | input | 1 | Command write strobe |
| wr_data_i | input | 32 | Command word |
| wr_secure_i | input | 1 | Write is a secure access |
| wr_cpu_i | input | CPU_W | ID of the requesting processor |
| rd_data_o | output | 32 | Read value of the command register (zero) |
| grp_cfg_i | input | NUM_CPU*16 | Group per CPU and interrupt, 1 = group 1 |
| ns_g0_ok_i | input | 16 | Per interrupt: non-secure writes may raise group 0 |
| ack_vld_i | input | NUM_CPU | Per-CPU acknowledge strobe |
| ack_id_i | input | NUM_CPU*4 | Per-CPU acknowledged interrupt number |
| pend_o | output | NUM_CPU*16 | Pending array, bit cpu*16+id |

## Verification
The bench builds the block with NUM_CPU set to 4. This makes a full cross product small enough to sweep: every requester ID, all four filter modes, both security states, both requested groups, and the normal, disabled and routing-mode cases. Each combination uses freshly scrambled group settings and permissions. At four CPUs the mask bits [23:20] are unused, so they join the reserved bits as garbage that must have no effect. Directed cases cover repeated writes, the set-over-clear collision and acknowledges for a different interrupt number.

// File: rtl/swi_pkg.sv
package swi_pkg;

  localparam int SWI_CMD_W   = 32;
  localparam int SWI_ID_W    = 4;
  localparam int SWI_NUM_ID  = 1 << SWI_ID_W;
  localparam int SWI_MASK_W  = 8;

  // field positions inside the command word
  localparam int SWI_ID_LSB   = 0;
  localparam int SWI_GRP_BIT  = 15;
  localparam int SWI_MASK_LSB = 16;
  localparam int SWI_FLT_LSB  = 24;

  typedef enum logic [1:0] {
    FLT_LIST   = 2'b00,
    FLT_OTHERS = 2'b01,
    FLT_SELF   = 2'b10,
    FLT_NONE   = 2'b11
  } swi_filter_e;

  typedef struct packed {
    swi_filter_e              filter;
    logic [SWI_MASK_W-1:0]    mask;
    logic                     grp;
    logic [SWI_ID_W-1:0]      id;
  } swi_cmd_t;

endpackage

// File: rtl/swi_cmd_decode.sv
module swi_cmd_decode
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input  logic [SWI_CMD_W-1:0] wr_data_i,
  input  logic [CPU_W-1:0]     req_cpu_i,
  output swi_cmd_t             cmd_o,
  output logic [NUM_CPU-1:0]   tgt_o
);

  swi_cmd_t cmd;
  logic     unused_bits;

  always_comb begin
    cmd.id     = wr_data_i[SWI_ID_LSB +: SWI_ID_W];
    cmd.grp    = wr_data_i[SWI_GRP_BIT];
    cmd.mask   = wr_data_i[SWI_MASK_LSB +: SWI_MASK_W];
    cmd.filter = swi_filter_e'(wr_data_i[SWI_FLT_LSB +: 2]);
  end

  assign unused_bits = ^{wr_data_i[SWI_CMD_W-1:SWI_FLT_LSB+2],
                         wr_data_i[SWI_GRP_BIT-1:SWI_ID_LSB+SWI_ID_W],
                         cmd.mask};

  assign cmd_o = cmd;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_tgt
    logic is_self;
    assign is_self = (req_cpu_i == CPU_W'(c));
    always_comb begin
      unique case (cmd.filter)
        FLT_LIST:   tgt_o[c] = cmd.mask[c];
        FLT_OTHERS: tgt_o[c] = !is_self;
        FLT_SELF:   tgt_o[c] = is_self;
        default:    tgt_o[c] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/swi_grp_filter.sv
module swi_grp_filter
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic [SWI_ID_W-1:0]           id_i,
  input  logic                          grp_sel_i,
  input  logic                          secure_i,
  input  logic [NUM_CPU*SWI_NUM_ID-1:0] grp_cfg_i,
  input  logic [SWI_NUM_ID-1:0]         ns_g0_ok_i,
  output logic [NUM_CPU-1:0]            allow_o
);

  logic ns_g0_ok;
  assign ns_g0_ok = ns_g0_ok_i[id_i];

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [SWI_NUM_ID-1:0] cfg_row;
    logic                  is_g1;
    assign cfg_row = grp_cfg_i[c*SWI_NUM_ID +: SWI_NUM_ID];
    assign is_g1   = cfg_row[id_i];
    always_comb begin
      if (secure_i) allow_o[c] = (grp_sel_i == is_g1);
      else          allow_o[c] = is_g1 | ns_g0_ok;
    end
  end

endmodule

// File: rtl/swi_pend_array.sv
module swi_pend_array
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          set_en_i,
  input  logic [NUM_CPU-1:0]            set_mask_i,
  input  logic [SWI_ID_W-1:0]           set_id_i,
  input  logic [NUM_CPU-1:0]            ack_vld_i,
  input  logic [NUM_CPU*SWI_ID_W-1:0]   ack_id_i,
  output logic [NUM_CPU*SWI_NUM_ID-1:0] pend_o
);

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_row
    logic [SWI_NUM_ID-1:0] row_q;
    logic [SWI_NUM_ID-1:0] row_d;
    logic [SWI_NUM_ID-1:0] set_row;
    logic [SWI_NUM_ID-1:0] clr_row;
    logic                  row_set;
    logic                  row_ce;

    // next state: clear first, set wins
    always_comb begin
      row_set = set_en_i & set_mask_i[c];
      set_row = '0;
      clr_row = '0;
      if (row_set)      set_row[set_id_i] = 1'b1;
      if (ack_vld_i[c]) clr_row[ack_id_i[c*SWI_ID_W +: SWI_ID_W]] = 1'b1;
      row_d  = (row_q & ~clr_row) | set_row;
      row_ce = row_set | ack_vld_i[c];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      row_q <= '0;
      else if (row_ce) row_q <= row_d;
    end

    assign pend_o[c*SWI_NUM_ID +: SWI_NUM_ID] = row_q;
  end

endmodule

// File: rtl/swi_dispatch.sv
module swi_dispatch
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  // derived, keep at default
  parameter int CPU_W   = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          dist_en_i,
  input  logic                          route_mode_i,
  input  logic                          wr_en_i,
  input  logic [SWI_CMD_W-1:0]          wr_data_i,
  input  logic                          wr_secure_i,
  input  logic [CPU_W-1:0]              wr_cpu_i,
  output logic [SWI_CMD_W-1:0]          rd_data_o,
  input  logic [NUM_CPU*SWI_NUM_ID-1:0] grp_cfg_i,
  input  logic [SWI_NUM_ID-1:0]         ns_g0_ok_i,
  input  logic [NUM_CPU-1:0]            ack_vld_i,
  input  logic [NUM_CPU*SWI_ID_W-1:0]   ack_id_i,
  output logic [NUM_CPU*SWI_NUM_ID-1:0] pend_o
);

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  swi_cmd_t           cmd;
  logic [NUM_CPU-1:0] tgt;
  logic [NUM_CPU-1:0] allow;
  logic [NUM_CPU-1:0] deliver;
  logic               accept;

  assign accept  = wr_en_i & dist_en_i & ~route_mode_i;
  assign deliver = tgt & allow;

  swi_cmd_decode #(
    .NUM_CPU (NUM_CPU),
    .CPU_W   (CPU_W)
  ) i_decode (
    .wr_data_i (wr_data_i),
    .req_cpu_i (wr_cpu_i),
    .cmd_o     (cmd),
    .tgt_o     (tgt)
  );

  swi_grp_filter #(
    .NUM_CPU (NUM_CPU)
  ) i_filter (
    .id_i       (cmd.id),
    .grp_sel_i  (cmd.grp),
    .secure_i   (wr_secure_i),
    .grp_cfg_i  (grp_cfg_i),
    .ns_g0_ok_i (ns_g0_ok_i),
    .allow_o    (allow)
  );

  swi_pend_array #(
    .NUM_CPU (NUM_CPU)
  ) i_pend (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .set_en_i   (accept),
    .set_mask_i (deliver),
    .set_id_i   (cmd.id),
    .ack_vld_i  (ack_vld_i),
    .ack_id_i   (ack_id_i),
    .pend_o     (pend_o)
  );

  // command register is write-only
  assign rd_data_o = '0;

endmodule

// File: rtl/swi_dispatch_chk.sv
module swi_dispatch_chk
  import swi_pkg::*;
#(
  parameter int NUM_CPU = 8,
  parameter int CPU_W   = 3
) (
  input logic                          clk,
  input logic                          rst_q_n,
  input logic                          dist_en_i,
  input logic                          route_mode_i,
  input logic                          wr_en_i,
  input logic [SWI_CMD_W-1:0]          wr_data_i,
  input logic                          wr_secure_i,
  input logic [CPU_W-1:0]              wr_cpu_i,
  input logic [NUM_CPU*SWI_NUM_ID-1:0] grp_cfg_i,
  input logic [NUM_CPU-1:0]            ack_vld_i,
  input logic [NUM_CPU*SWI_ID_W-1:0]   ack_id_i,
  input logic [NUM_CPU*SWI_NUM_ID-1:0] pend_o
);

  logic [1:0]          cmd_flt;
  logic [SWI_ID_W-1:0] cmd_id;
  logic                cmd_grp;
  logic                live;

  assign cmd_flt = wr_data_i[SWI_FLT_LSB +: 2];
  assign cmd_id  = wr_data_i[SWI_ID_LSB +: SWI_ID_W];
  assign cmd_grp = wr_data_i[SWI_GRP_BIT];
  assign live    = wr_en_i & dist_en_i & ~route_mode_i;

  // R5
  no_set_reserved_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en_i && cmd_flt == 2'b11) |=> ((pend_o & ~$past(pend_o)) == '0));

  // R8
  no_set_routed_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en_i && route_mode_i) |=> ((pend_o & ~$past(pend_o)) == '0));

  // R9
  no_set_disabled_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en_i && !dist_en_i) |=> ((pend_o & ~$past(pend_o)) == '0));

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [SWI_NUM_ID-1:0] prow;
    logic [SWI_NUM_ID-1:0] cfg_row;
    logic [SWI_ID_W-1:0]   aid;
    assign prow    = pend_o[c*SWI_NUM_ID +: SWI_NUM_ID];
    assign cfg_row = grp_cfg_i[c*SWI_NUM_ID +: SWI_NUM_ID];
    assign aid     = ack_id_i[c*SWI_ID_W +: SWI_ID_W];

    // R3
    others_skip_self_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en_i && cmd_flt == 2'b01 && wr_cpu_i == CPU_W'(c))
      |=> ((prow & ~$past(prow)) == '0));

    // R4
    self_only_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en_i && cmd_flt == 2'b10 && wr_cpu_i != CPU_W'(c))
      |=> ((prow & ~$past(prow)) == '0));

    // R10
    self_set_next_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (live && cmd_flt == 2'b10 && wr_secure_i && wr_cpu_i == CPU_W'(c)
       && cmd_grp == cfg_row[cmd_id]) |=> prow[$past(cmd_id)]);

    // R6
    secure_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (wr_en_i && wr_secure_i && cmd_grp != cfg_row[cmd_id] && !prow[cmd_id]
       && !(ack_vld_i[c] && aid == cmd_id)) |=> !prow[$past(cmd_id)]);

    // R11
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
      (ack_vld_i[c] && !wr_en_i) |=> !prow[$past(aid)]);
  end

endmodule

bind swi_dispatch swi_dispatch_chk #(
  .NUM_CPU (NUM_CPU),
  .CPU_W   (CPU_W)
) i_chk (.*);

// File: tb/test_swi_dispatch.sv
`timescale 1ns/1ps
module test_swi_dispatch;

  localparam int NCPU = 4;
  localparam int CW   = 2;
  localparam int NID  = 16;

  logic              clk;
  logic              rst_n;
  logic              dist_en;
  logic              route_mode;
  logic              wr_en;
  logic [31:0]       wr_data;
  logic              wr_secure;
  logic [CW-1:0]     wr_cpu;
  logic [31:0]       rd_data;
  logic [NCPU*NID-1:0] grp_cfg;
  logic [NID-1:0]    ns_ok;
  logic [NCPU-1:0]   ack_vld;
  logic [NCPU*4-1:0] ack_id;
  logic [NCPU*NID-1:0] pend;

  int n_chk;
  int n_fail;
  bit done;
  logic [31:0] rng;
  logic [NCPU*NID-1:0] exp_pend;

  swi_dispatch #(.NUM_CPU(NCPU)) i_swi_dispatch (
    .clk(clk), .rst_n(rst_n), .dist_en_i(dist_en), .route_mode_i(route_mode),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .wr_secure_i(wr_secure),
    .wr_cpu_i(wr_cpu), .rd_data_o(rd_data), .grp_cfg_i(grp_cfg),
    .ns_g0_ok_i(ns_ok), .ack_vld_i(ack_vld), .ack_id_i(ack_id), .pend_o(pend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] next_rng(logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic check(string tag, logic [NCPU*NID-1:0] act, logic [NCPU*NID-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  // one write cycle; outputs sampled on the following falling edge
  task automatic do_write(logic [31:0] d, logic sec, logic [CW-1:0] req);
    wr_data = d; wr_secure = sec; wr_cpu = req; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic ack_all(logic [3:0] id);
    ack_vld = '1; ack_id = {NCPU{id}};
    @(negedge clk);
    ack_vld = '0;
  endtask

  // expected targets from filter mode (R2..R5)
  function automatic logic [NCPU-1:0] exp_tgt(int flt, logic [7:0] m, int r);
    case (flt)
      0: return m[NCPU-1:0];
      1: return ~(NCPU'(1) << r);
      2: return NCPU'(1) << r;
      default: return '0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; rng = 32'h1234_5677;
    rst_n = 1'b0; dist_en = 1'b1; route_mode = 1'b0; wr_en = 1'b0;
    wr_data = '0; wr_secure = 1'b1; wr_cpu = '0; grp_cfg = '0; ns_ok = '0;
    ack_vld = '0; ack_id = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R13 reset state, R12 read value
    check("R13", pend, '0);
    check("R12", {32'h0, rd_data}, '0);

    // R10 timing and single pending after repeats: secure, group 1, CPU 2 self
    grp_cfg = '1;
    do_write({6'h0, 2'b10, 8'h00, 1'b1, 11'h0, 4'd9}, 1'b1, 2'd2);
    exp_pend = '0; exp_pend[2*NID+9] = 1'b1;
    check("R10", pend, exp_pend);
    do_write({6'h0, 2'b10, 8'h00, 1'b1, 11'h0, 4'd9}, 1'b1, 2'd2);
    do_write({6'h0, 2'b10, 8'h00, 1'b1, 11'h0, 4'd9}, 1'b1, 2'd2);
    check("R10", pend, exp_pend);
    // R11 acknowledge of another number leaves it
    ack_vld = 4'b0100; ack_id = {4'd0, 4'd3, 4'd0, 4'd0};
    @(negedge clk); ack_vld = '0;
    check("R11", pend, exp_pend);
    // R11/R10 one acknowledge clears the single pending bit
    ack_vld = 4'b0100; ack_id = {4'd0, 4'd9, 4'd0, 4'd0};
    @(negedge clk); ack_vld = '0;
    check("R11", pend, '0);
    // R11 set wins over simultaneous clear
    ack_vld = 4'b0001; ack_id = {4'd0, 4'd0, 4'd0, 4'd5};
    do_write({6'h0, 2'b10, 8'h00, 1'b1, 11'h0, 4'd5}, 1'b1, 2'd0);
    ack_vld = '0;
    exp_pend = '0; exp_pend[0*NID+5] = 1'b1;
    check("R11", pend, exp_pend);
    ack_all(4'd5);
    check("R11", pend, '0);
    // R2 zero mask
    do_write({6'h0, 2'b00, 8'h00, 1'b1, 11'h0, 4'd1}, 1'b1, 2'd1);
    check("R2", pend, '0);

    // sweep: requester x filter x security x group x enable case
    for (int r = 0; r < NCPU; r++)
      for (int f = 0; f < 4; f++)
        for (int s = 0; s < 2; s++)
          for (int g = 0; g < 2; g++)
            for (int e = 0; e < 3; e++) begin
              logic [3:0]      id;
              logic [7:0]      m;
              logic [31:0]     w;
              logic [NCPU-1:0] t;
              logic            ok;
              string           tag;
              rng = next_rng(rng); grp_cfg[31:0]  = rng;
              rng = next_rng(rng); grp_cfg[63:32] = rng;
              rng = next_rng(rng); ns_ok = rng[15:0];
              id = rng[19:16] ^ 4'(r * 5 + f * 3 + e);
              rng = next_rng(rng); m = rng[7:0];
              // garbage in reserved and unused mask bits (R1)
              w = {rng[31:26], 2'(f), m[7:4] ^ rng[27:24], m[3:0], 1'(g), rng[14:4], id};
              dist_en    = (e != 1);
              route_mode = (e == 2);
              t = exp_tgt(f, w[23:16], r);
              exp_pend = '0;
              for (int c = 0; c < NCPU; c++) begin
                logic g1;
                g1 = grp_cfg[c*NID + id];
                ok = s ? (g1 == 1'(g)) : (g1 | ns_ok[id]);
                if (e == 0 && t[c] && ok) exp_pend[c*NID + id] = 1'b1;
              end
              if (e == 1) tag = "R9";
              else if (e == 2) tag = "R8";
              else if (f == 3) tag = "R5";
              else if (s == 0) tag = "R7";
              else if (f == 0) tag = "R2/R6";
              else if (f == 1) tag = "R3/R6";
              else tag = "R4/R6/R1";
              do_write(w, 1'(s), CW'(r));
              check(tag, pend, exp_pend);
              dist_en = 1'b1; route_mode = 1'b0;
              ack_all(id);
              check("R11", pend, '0);
              check("R12", {32'h0, rd_data}, '0);
            end

    finish_run();
  end

endmodule